// File: doc/BRIEF.md
# Serial Debug RAM Word Injector

This block lets an external debug host overwrite one 32-bit word of an on-chip RAM while the CPU keeps running. The host clocks a stream of 32-bit frames into the chip over a serial clock and a receive line, least-significant bit first. A write request uses two frames in a row: a command frame that holds a 4-bit operation code and a word address, then a data frame that holds the word to be written. Frames whose code is not recognised are dropped without any effect.

Once the data frame has arrived, the block waits until the third frame period after it begins. It then drives a single write cycle into the RAM port, but only in a clock cycle where the CPU is not using the RAM. The RAM port is shared through a small multiplexer that always lets a CPU request through unchanged, so CPU traffic never waits. If the CPU is busy for the whole eligible window, the write stays pending and goes out on the first free cycle. While a write is pending, incoming frames are not decoded.

The serial inputs are sampled in the system clock domain through a short synchroniser. A recovery code exists so that the host can resynchronise the stream; a write command that comes directly after it is only taken when its twelve upper tag bits are all ones.

Top module: `dbg_ram_inject`

## Requirements
- R1: Serial bits are taken on rising edges of `dbg_sclk` and assembled LSB-first into 32-bit frames; the frame after an accepted write command is the write data, delivered unchanged on `ram_wdata`.
- R2: A command frame starts a write only when its bits [15:12] equal the write code (default 4'h6); every other code is dropped and produces no RAM write.
- R3: The word address is taken from command bits [19:16] and driven on `ram_addr`; command bits [1:0] (the byte offset) are ignored, so every write is word aligned.
- R4: With the CPU idle, the RAM write occurs right after the 64th serial rising edge that follows the data frame, i.e. at the start of the third frame period after the data.
- R5: Whenever `cpu_req` is high the RAM port carries the CPU's enable, write flag, address, data and byte enables unchanged; a debug write only appears in cycles where `cpu_req` is low.
- R6: If the CPU is busy when the write becomes eligible, the write is held and issued in the first cycle in which `cpu_req` is low.
- R7: Each accepted command produces exactly one single-cycle RAM write with `ram_we` high and `ram_be` equal to 4'hF.
- R8: While a write is pending, further frames (including new write commands) are ignored and do not change the pending address or data.
- R9: A write command frame that directly follows a recovery frame (code 4'hE) is accepted only when its bits [31:20] are all ones; in any other position those bits are ignored.
- R10: A synchronous active-high `rst` clears the bit counter, the shift register and any pending write; after release, frames are counted from the next serial bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| dbg_sclk | input | 1 | Serial clock from the debug host |
| dbg_rxd | input | 1 | Serial receive data, LSB first |
| cpu_req | input | 1 | CPU requests the RAM this cycle |
| cpu_we | input | 1 | CPU write flag |
| cpu_addr | input | AW | CPU word address |
| cpu_wdata | input | 32 | CPU write data |
| cpu_be | input | 4 | CPU byte enables |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write flag |
| ram_addr | output | AW | RAM word address |
| ram_wdata | output | 32 | RAM write data |
| ram_be | output | 4 | RAM byte enables |

## Verification
The assertions assume the serial clock is much slower than the system clock, with each level held for more than the synchroniser depth plus one cycle, and that `dbg_rxd` is stable around each serial rising edge; they also assume the host keeps frames aligned to the bit counter from reset. The stimulus holds each serial level for four system clocks, changes `dbg_rxd` only while `dbg_sclk` is low, always sends whole frames, and drives CPU inputs one time unit after the clock edge so no decision depends on process order.

// File: rtl/dbg_inj_pkg.sv
package dbg_inj_pkg;
    localparam int FRAME_W  = 32;
    localparam int CODE_LSB = 12;
    localparam int CODE_W   = 4;
    localparam int ADDR_LSB = 16;
    localparam int TAG_LSB  = 20;
    localparam int TAG_W    = FRAME_W - TAG_LSB;
    localparam int BE_W     = FRAME_W / 8;

    typedef enum logic [1:0] {
        SQ_CMD  = 2'd0,
        SQ_DATA = 2'd1,
        SQ_HOLD = 2'd2
    } seq_state_e;
endpackage

// File: rtl/dbg_sclk_sync.sv
module dbg_sclk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk_in,
    input  logic rxd_in,
    output logic bit_stb,
    output logic bit_val
);
    typedef struct packed {
        logic [STAGES:0]   sc;
        logic [STAGES-1:0] rd;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d       = sync_q;
        sync_d.sc[0] = sclk_in;
        sync_d.rd[0] = rxd_in;
        for (int i = 1; i <= STAGES; i++) sync_d.sc[i] = sync_q.sc[i-1];
        for (int i = 1; i < STAGES; i++)  sync_d.rd[i] = sync_q.rd[i-1];
    end

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= sync_d;
    end

    assign bit_stb = sync_q.sc[STAGES-1] & ~sync_q.sc[STAGES];
    assign bit_val = sync_q.rd[STAGES-1];
endmodule

// File: rtl/dbg_frame_rx.sv
module dbg_frame_rx
    import dbg_inj_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               bit_stb,
    input  logic               bit_val,
    output logic               frame_vld,
    output logic [FRAME_W-1:0] frame
);
    localparam int CNT_W = $clog2(FRAME_W);

    typedef struct packed {
        logic [FRAME_W-1:0] sr;
        logic [CNT_W-1:0]   cnt;
        logic               vld;
        logic [FRAME_W-1:0] frm;
    } rx_t;

    rx_t rx_d, rx_q;

    always_comb begin
        rx_d     = rx_q;
        rx_d.vld = 1'b0;
        if (bit_stb) begin
            rx_d.sr  = {bit_val, rx_q.sr[FRAME_W-1:1]};
            rx_d.cnt = rx_q.cnt + 1'b1;
            if (rx_q.cnt == CNT_W'(FRAME_W - 1)) begin
                rx_d.cnt = '0;
                rx_d.vld = 1'b1;
                rx_d.frm = {bit_val, rx_q.sr[FRAME_W-1:1]};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rx_q <= '0;
        else     rx_q <= rx_d;
    end

    assign frame_vld = rx_q.vld;
    assign frame     = rx_q.frm;

    // R1
    one_frame_per_window_chk: assert property (@(posedge clk) disable iff (rst)
        frame_vld |=> !frame_vld);
endmodule

// File: rtl/dbg_wr_seq.sv
module dbg_wr_seq
    import dbg_inj_pkg::*;
#(
    parameter int          AW           = 4,
    parameter logic [3:0]  CMD_WRITE    = 4'h6,
    parameter logic [3:0]  CMD_RCV      = 4'hE,
    parameter int          DELAY_FRAMES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               frame_vld,
    input  logic [FRAME_W-1:0] frame,
    input  logic               cpu_req,
    output logic               wr_go,
    output logic [AW-1:0]      wr_addr,
    output logic [FRAME_W-1:0] wr_data
);
    localparam int FC_W = $clog2(DELAY_FRAMES + 1);

    typedef struct packed {
        seq_state_e         st;
        logic [FC_W-1:0]    fcnt;
        logic [AW-1:0]      addr;
        logic [FRAME_W-1:0] data;
        logic               rcv;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [CODE_W-1:0] code;
    logic              tag_ones;
    logic              unused_bits;

    assign code        = frame[CODE_LSB +: CODE_W];
    assign tag_ones    = &frame[TAG_LSB +: TAG_W];
    assign unused_bits = ^frame[CODE_LSB-1:0];

    always_comb begin
        seq_d = seq_q;
        wr_go = 1'b0;
        unique case (seq_q.st)
            SQ_CMD: begin
                if (frame_vld) begin
                    if (code == CMD_WRITE && (!seq_q.rcv || tag_ones)) begin
                        seq_d.st   = SQ_DATA;
                        seq_d.addr = frame[ADDR_LSB +: AW];
                    end
                    seq_d.rcv = (code == CMD_RCV);
                end
            end
            SQ_DATA: begin
                if (frame_vld) begin
                    seq_d.data = frame;
                    seq_d.fcnt = '0;
                    seq_d.st   = SQ_HOLD;
                end
            end
            SQ_HOLD: begin
                if (seq_q.fcnt == FC_W'(DELAY_FRAMES)) begin
                    if (!cpu_req) begin
                        wr_go    = 1'b1;
                        seq_d.st = SQ_CMD;
                    end
                end else if (frame_vld) begin
                    seq_d.fcnt = seq_q.fcnt + 1'b1;
                end
            end
            default: seq_d.st = SQ_CMD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) seq_q <= '0;
        else     seq_q <= seq_d;
    end

    assign wr_addr = seq_q.addr;
    assign wr_data = seq_q.data;

    // R7
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        wr_go |=> !wr_go);

    // R8
    pending_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (seq_q.st == SQ_HOLD && $past(seq_q.st) == SQ_HOLD)
            |-> ($stable(seq_q.addr) && $stable(seq_q.data)));

    // R4
    no_early_write_chk: assert property (@(posedge clk) disable iff (rst)
        (seq_q.st == SQ_DATA && frame_vld) |=> !wr_go);
endmodule

// File: rtl/dbg_ram_mux.sv
module dbg_ram_mux
    import dbg_inj_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cpu_req,
    input  logic               cpu_we,
    input  logic [AW-1:0]      cpu_addr,
    input  logic [FRAME_W-1:0] cpu_wdata,
    input  logic [BE_W-1:0]    cpu_be,
    input  logic               dbg_go,
    input  logic [AW-1:0]      dbg_addr,
    input  logic [FRAME_W-1:0] dbg_data,
    output logic               ram_en,
    output logic               ram_we,
    output logic [AW-1:0]      ram_addr,
    output logic [FRAME_W-1:0] ram_wdata,
    output logic [BE_W-1:0]    ram_be
);
    always_comb begin
        if (cpu_req) begin
            ram_en    = 1'b1;
            ram_we    = cpu_we;
            ram_addr  = cpu_addr;
            ram_wdata = cpu_wdata;
            ram_be    = cpu_be;
        end else begin
            ram_en    = dbg_go;
            ram_we    = dbg_go;
            ram_addr  = dbg_addr;
            ram_wdata = dbg_data;
            ram_be    = {BE_W{dbg_go}};
        end
    end

    // R7
    full_word_write_chk: assert property (@(posedge clk) disable iff (rst)
        (ram_en && !cpu_req) |-> (ram_we && ram_be == {BE_W{1'b1}}));
endmodule

// File: rtl/dbg_ram_inject.sv
module dbg_ram_inject
    import dbg_inj_pkg::*;
#(
    parameter int         AW           = 4,
    parameter int         SYNC_STAGES  = 2,
    parameter logic [3:0] CMD_WRITE    = 4'h6,
    parameter logic [3:0] CMD_RCV      = 4'hE,
    parameter int         DELAY_FRAMES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          dbg_sclk,
    input  logic          dbg_rxd,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [31:0]   cpu_wdata,
    input  logic [3:0]    cpu_be,
    output logic          ram_en,
    output logic          ram_we,
    output logic [AW-1:0] ram_addr,
    output logic [31:0]   ram_wdata,
    output logic [3:0]    ram_be
);
    logic               bit_stb;
    logic               bit_val;
    logic               frame_vld;
    logic [FRAME_W-1:0] frame;
    logic               wr_go;
    logic [AW-1:0]      wr_addr;
    logic [FRAME_W-1:0] wr_data;

    dbg_sclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .sclk_in (dbg_sclk),
        .rxd_in  (dbg_rxd),
        .bit_stb (bit_stb),
        .bit_val (bit_val)
    );

    dbg_frame_rx u_rx (
        .clk       (clk),
        .rst       (rst),
        .bit_stb   (bit_stb),
        .bit_val   (bit_val),
        .frame_vld (frame_vld),
        .frame     (frame)
    );

    dbg_wr_seq #(
        .AW           (AW),
        .CMD_WRITE    (CMD_WRITE),
        .CMD_RCV      (CMD_RCV),
        .DELAY_FRAMES (DELAY_FRAMES)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .frame_vld (frame_vld),
        .frame     (frame),
        .cpu_req   (cpu_req),
        .wr_go     (wr_go),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data)
    );

    dbg_ram_mux #(.AW(AW)) u_mux (
        .clk       (clk),
        .rst       (rst),
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_be    (cpu_be),
        .dbg_go    (wr_go),
        .dbg_addr  (wr_addr),
        .dbg_data  (wr_data),
        .ram_en    (ram_en),
        .ram_we    (ram_we),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata),
        .ram_be    (ram_be)
    );
endmodule

// File: tb/sim_dbg_ram_inject.sv
module sim_dbg_ram_inject;
    localparam int AW = 4;
    localparam logic [3:0] WR  = 4'h6;
    localparam logic [3:0] RCV = 4'hE;
    localparam logic [31:0] IDLE = 32'hFFFF_FFFF;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sclk = 1'b0;
    logic          rxd = 1'b1;
    logic          cpu_req = 1'b0;
    logic          cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [31:0]   cpu_wdata = '0;
    logic [3:0]    cpu_be = '0;
    logic          ram_en, ram_we;
    logic [AW-1:0] ram_addr;
    logic [31:0]   ram_wdata;
    logic [3:0]    ram_be;

    int errs = 0, checks = 0, bitno = 0, cyc = 0, cpu_mode = 0;
    int wr_cnt = 0, wr_bit = 0, wr_cyc = 0, last_busy = 0, bad_shape = 0, mux_bad = 0;
    logic [AW-1:0] wr_addr = '0;
    logic [31:0]   wr_data = '0;

    dbg_ram_inject #(.AW(AW)) u0 (
        .clk(clk), .rst(rst), .dbg_sclk(sclk), .dbg_rxd(rxd),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_be(cpu_be),
        .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_be(ram_be)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst) begin
            if (cpu_req) begin
                last_busy = cyc;
                if (!(ram_en && ram_we == cpu_we && ram_addr == cpu_addr &&
                      ram_wdata == cpu_wdata && ram_be == cpu_be)) mux_bad++;
            end else if (ram_en) begin
                wr_cnt++;
                wr_addr = ram_addr;
                wr_data = ram_wdata;
                wr_bit  = bitno;
                wr_cyc  = cyc;
                if (!(ram_we && ram_be == 4'hF)) bad_shape++;
            end
        end
    end

    initial begin
        forever begin
            @(posedge clk); #1;
            case (cpu_mode)
                1: cpu_req = 1'b1;
                2: cpu_req = ~cpu_req;
                default: cpu_req = 1'b0;
            endcase
            cpu_we    = ~cpu_we;
            cpu_addr  = cpu_addr + 1'b1;
            cpu_wdata = cpu_wdata + 32'h1111_0101;
            cpu_be    = cpu_be + 1'b1;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        rxd = b;
        tick(4);
        sclk = 1'b1;
        bitno++;
        tick(4);
        sclk = 1'b0;
    endtask

    task automatic send_frame(input logic [31:0] w);
        for (int i = 0; i < 32; i++) send_bit(w[i]);
    endtask

    function automatic logic [31:0] mk_cmd(input logic [3:0] code, input logic [3:0] wa,
                                           input logic [1:0] bo, input logic [11:0] tag);
        return {tag, wa, code, 10'h000, bo};
    endfunction

    task automatic cmd_data(input logic [31:0] c, input logic [31:0] d, output int dend);
        send_frame(c);
        send_frame(d);
        dend = bitno;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++; checks++;
        $display("FAIL R1 watchdog expired: actual=%0d expected=0", cyc);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        int dend, base;
        logic [31:0] d;
        tick(5);
        // R10: reset state
        chk(ram_en == 1'b0, "R10", "ram_en in reset", 32'(ram_en), 32'h0);
        rst = 1'b0;
        tick(3);
        chk(ram_en == 1'b0, "R10", "ram_en after reset", 32'(ram_en), 32'h0);
        send_frame(IDLE);

        // R1 R3 R4 R7: sweep over every word address with varied byte offsets and tags
        for (int i = 0; i < 16; i++) begin
            base = wr_cnt;
            d = 32'h9E37_79B9 * 32'(i + 1);
            cmd_data(mk_cmd(WR, 4'(i), 2'(i), 12'(i * 37)), d, dend);
            repeat (3) send_frame(IDLE);
            chk(wr_cnt == base + 1, "R7", "write count", 32'(wr_cnt), 32'(base + 1));
            chk(wr_addr == 4'(i), "R3", "word address", 32'(wr_addr), 32'(i));
            chk(wr_data == d, "R1", "write data", wr_data, d);
            chk(wr_bit == dend + 64, "R4", "write bit position", 32'(wr_bit), 32'(dend + 64));
        end

        // R2: every other code is dropped
        for (int c = 0; c < 16; c++) begin
            if (c != int'(WR)) begin
                base = wr_cnt;
                send_frame(mk_cmd(4'(c), 4'h5, 2'b00, 12'h000));
                send_frame(32'h1234_F678);
                repeat (3) send_frame(IDLE);
                chk(wr_cnt == base, "R2", "write from unknown code", 32'(wr_cnt), 32'(base));
            end
        end

        // R9: after recovery the tag bits must be all ones
        base = wr_cnt;
        send_frame(mk_cmd(RCV, 4'h0, 2'b00, 12'h000));
        send_frame(mk_cmd(WR, 4'h3, 2'b00, 12'h7FF));
        send_frame(32'h1234_F678);
        repeat (3) send_frame(IDLE);
        chk(wr_cnt == base, "R9", "write after recovery with bad tag", 32'(wr_cnt), 32'(base));
        send_frame(mk_cmd(RCV, 4'h0, 2'b00, 12'h000));
        cmd_data(mk_cmd(WR, 4'h9, 2'b11, 12'hFFF), 32'h0BAD_F00D, dend);
        repeat (3) send_frame(IDLE);
        chk(wr_cnt == base + 1, "R9", "write after recovery with full tag", 32'(wr_cnt), 32'(base + 1));
        chk(wr_addr == 4'h9, "R9", "address after recovery", 32'(wr_addr), 32'h9);

        // R8: frames during the pending window are ignored
        base = wr_cnt;
        cmd_data(mk_cmd(WR, 4'h2, 2'b00, 12'h000), 32'hC001_D00D, dend);
        send_frame(mk_cmd(WR, 4'hB, 2'b00, 12'h000));
        send_frame(32'h5555_AAAA);
        repeat (4) send_frame(IDLE);
        chk(wr_cnt == base + 1, "R8", "writes with pending overlap", 32'(wr_cnt), 32'(base + 1));
        chk(wr_addr == 4'h2, "R8", "pending address kept", 32'(wr_addr), 32'h2);
        chk(wr_data == 32'hC001_D00D, "R8", "pending data kept", wr_data, 32'hC001_D00D);

        // R6: CPU busy across the whole window
        cpu_mode = 1;
        tick(2);
        base = wr_cnt;
        cmd_data(mk_cmd(WR, 4'hC, 2'b01, 12'h000), 32'h7E57_0C0C, dend);
        repeat (4) send_frame(IDLE);
        chk(wr_cnt == base, "R6", "write while CPU busy", 32'(wr_cnt), 32'(base));
        cpu_mode = 0;
        tick(6);
        chk(wr_cnt == base + 1, "R6", "held write issued", 32'(wr_cnt), 32'(base + 1));
        chk(wr_cyc == last_busy + 1, "R6", "first idle cycle", 32'(wr_cyc), 32'(last_busy + 1));
        chk(wr_data == 32'h7E57_0C0C, "R6", "held data", wr_data, 32'h7E57_0C0C);

        // R5: alternating CPU traffic
        cpu_mode = 2;
        base = wr_cnt;
        cmd_data(mk_cmd(WR, 4'hD, 2'b10, 12'h000), 32'h0F1E_2D3C, dend);
        repeat (3) send_frame(IDLE);
        cpu_mode = 0;
        tick(3);
        chk(wr_cnt == base + 1, "R5", "write under CPU traffic", 32'(wr_cnt), 32'(base + 1));
        chk(wr_bit >= dend + 64 && wr_bit <= dend + 65, "R5", "write slot", 32'(wr_bit), 32'(dend + 64));
        chk(wr_data == 32'h0F1E_2D3C, "R5", "data under traffic", wr_data, 32'h0F1E_2D3C);

        // R10: reset drops a pending write
        base = wr_cnt;
        cmd_data(mk_cmd(WR, 4'h1, 2'b00, 12'h000), 32'hDEAD_0001, dend);
        send_frame(IDLE);
        rst = 1'b1;
        tick(3);
        rst = 1'b0;
        tick(2);
        repeat (4) send_frame(IDLE);
        chk(wr_cnt == base, "R10", "pending write after reset", 32'(wr_cnt), 32'(base));

        // R10: reset in mid frame restarts frame counting
        d = mk_cmd(WR, 4'h4, 2'b00, 12'h000);
        for (int i = 0; i < 10; i++) send_bit(d[i]);
        rst = 1'b1;
        tick(3);
        rst = 1'b0;
        tick(2);
        base = wr_cnt;
        cmd_data(mk_cmd(WR, 4'h7, 2'b00, 12'h000), 32'h7777_1234, dend);
        repeat (3) send_frame(IDLE);
        chk(wr_cnt == base + 1, "R10", "write after mid-frame reset", 32'(wr_cnt), 32'(base + 1));
        chk(wr_addr == 4'h7, "R10", "address after mid-frame reset", 32'(wr_addr), 32'h7);
        chk(wr_bit == dend + 64, "R10", "timing after reset", 32'(wr_bit), 32'(dend + 64));

        // R7 R5: shape of every debug write and CPU pass-through
        chk(bad_shape == 0, "R7", "write strobe shape", 32'(bad_shape), 32'h0);
        chk(mux_bad == 0, "R5", "CPU pass-through mismatches", 32'(mux_bad), 32'h0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule